// File: doc/BRIEF.md
# Weighted-Fairness DMA Channel Arbiter

This block decides, one bus transaction at a time, which of a set of DMA channels may use a shared bus. A CPU request outranks every channel. Each channel brings a request line, a 3-bit priority level and a round-robin enable bit. Level 0 is the most urgent and level 7 the least. A global fairness switch selects one of two schemes. The first is plain strict priority. The second guarantees the lower levels a geometrically shrinking share of the transaction slots that the CPU and the two most urgent levels leave unused.

A grant is a one-hot channel vector together with a valid flag. The grant stays fixed until the granted channel raises the transaction-done handshake. The arbiter then drops the grant and picks again on the next clock edge, so a more urgent channel can take over only at a transaction boundary. Within a level, requesters take turns. A channel with its round-robin enable cleared jumps ahead of the others at its level.

Top module: `dmaArbiter`

## Requirements
- R1: At most one bit of `grantVec` is set, and `grantValid` is high exactly when one bit is set.
- R2: While `cpuReq` is high and no grant is active, no new DMA grant is issued and `cpuGnt` is high. `cpuGnt` is low whenever a DMA grant is active.
- R3: When fairness is off, or when any channel at level 0 or 1 requests, the grant goes to the requesting level with the smallest number.
- R4: An active grant holds its value until `xferDone` is sampled high. It is cleared at that edge, and a new grant can appear no earlier than the following edge, even if a more urgent channel is waiting.
- R5: When idle, with no CPU request and at least one channel request, a grant appears at the next rising edge and goes to a channel that was requesting. With no request, nothing is granted.
- R6: With fairness on and no request at levels 0–1, a 6-bit slot count picks a favoured level. The count is odd: level 2. It is 2 mod 4: level 3. It is 4 mod 8: level 4. It is 8 mod 16: level 5. It is 16 mod 32: level 6. It is 32 or 0: level 7. A requesting favoured level wins the slot.
- R7: If the favoured level has no request, the slot goes to strict priority order.
- R8: Within a level, requesters are served round robin in ascending channel index, starting after the last channel whose transaction was completed at that level. That position moves only on `xferDone`. After reset the search starts at channel 0.
- R9: A requesting channel with its round-robin enable at 0 goes ahead of all round-robin channels at its level. Among several such channels, the lowest index wins.
- R10: After reset, `grantVec` is 0, `grantValid` is 0 and the slot count is 0.
- R11: The slot count steps by one for each grant issued at level 2 or above, whether fairness is on or off. Grants at levels 0–1 leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | CPU bus request, outranks all channels |
| cpuGnt | output | 1 | CPU may use the bus (no DMA grant active) |
| chReq | input | NUM_CH | Per-channel request |
| chLevel | input | NUM_CH*LVL_W | Per-channel priority level; channel i uses bits [i*LVL_W +: LVL_W] |
| rrEn | input | NUM_CH | Per-channel round-robin enable; 0 = head of its level |
| fairEn | input | 1 | 1 = bandwidth-sharing slots, 0 = strict priority |
| xferDone | input | 1 | The granted transaction ends this cycle |
| grantVec | output | NUM_CH | One-hot granted channel |
| grantValid | output | 1 | A DMA grant is active |

## Verification
Channels are given fixed levels, three per level, and a sequence of request sets is applied one transaction at a time. This walks the slot count through odd, 2-mod-4, 4-mod-8, 8-mod-16 and zero values. A wrong trailing-zero map, a slot count that also steps on level 0–1 grants, or a missing fall-back each leads to a different channel at some step. Repeated request sets at a single level tell a rotating pointer from a fixed pick and from a pointer that ignores the done handshake. A cleared round-robin bit shows whether head-of-line overrides the rotation. Directed sequences hold a CPU request across idle and busy periods, and raise an urgent request in the middle of a transaction, to separate proper override from preemption that breaks a transaction.

// File: rtl/dmaArbPkg.sv
package dmaArbPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;   // latch the current pick as the new grant
    logic retire;  // clear the grant and advance the level pointer
  } arbStrobeT;

  // first level that takes part in slot sharing
  localparam int FAIR_BASE = 2;

endpackage

// File: rtl/dmaArbLevelPick.sv
module dmaArbLevelPick #(
  parameter int NUM_CH = 24,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] member,   // requesting channels at this level
  input  logic [NUM_CH-1:0] rrEn,
  input  logic [CH_W-1:0]   lastIdx,  // last completed channel at this level
  output logic [NUM_CH-1:0] pickOh,
  output logic              hit
);

  logic [NUM_CH-1:0] headMask;
  logic              found;
  logic [CH_W-1:0]   sel;

  assign headMask = member & ~rrEn;
  assign hit      = |member;

  always_comb begin
    pickOh = '0;
    found  = 1'b0;
    sel    = '0;
    // head-of-line channels first, lowest index wins
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && headMask[i]) begin
        pickOh[i] = 1'b1;
        found     = 1'b1;
      end
    end
    // rotating search starting after the last served channel
    for (int k = 1; k <= NUM_CH; k++) begin
      sel = CH_W'((int'(lastIdx) + k) % NUM_CH);
      if (!found && member[sel]) begin
        pickOh[sel] = 1'b1;
        found       = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dmaArbDatapath.sv
module dmaArbDatapath
  import dmaArbPkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int LVL_W  = 3,
  parameter int SLOT_W = 6,
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       chReq,
  input  logic [NUM_CH*LVL_W-1:0] chLevel,
  input  logic [NUM_CH-1:0]       rrEn,
  input  logic                    fairEn,
  input  arbStrobeT               strb,
  output logic                    pickValid,
  output logic [NUM_CH-1:0]       grantVec
);

  logic [LVL_W-1:0]  lvlOf   [NUM_CH];
  logic [NUM_CH-1:0] lvlMask [NUM_LVL];
  logic [NUM_CH-1:0] lvlPick [NUM_LVL];
  logic [CH_W-1:0]   lastIdx [NUM_LVL];
  logic [NUM_LVL-1:0] lvlHit;

  logic [SLOT_W-1:0] slotCnt;
  logic [LVL_W-1:0]  grantLvl;
  logic [LVL_W-1:0]  strictLvl;
  logic [LVL_W-1:0]  favLvl;
  logic [LVL_W-1:0]  chosenLvl;
  logic              urgentHit;
  logic [NUM_CH-1:0] pickVec;

  // unpack level fields
  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_unpack
      assign lvlOf[gc] = chLevel[gc*LVL_W +: LVL_W];
    end
  endgenerate

  // one picker per level
  genvar gl;
  generate
    for (gl = 0; gl < NUM_LVL; gl++) begin : g_level
      always_comb begin
        for (int c = 0; c < NUM_CH; c++)
          lvlMask[gl][c] = chReq[c] && (lvlOf[c] == LVL_W'(gl));
      end

      dmaArbLevelPick #(.NUM_CH(NUM_CH)) u_pick (
        .member  (lvlMask[gl]),
        .rrEn    (rrEn),
        .lastIdx (lastIdx[gl]),
        .pickOh  (lvlPick[gl]),
        .hit     (lvlHit[gl])
      );
    end
  endgenerate

  // strict order: lowest numbered requesting level
  always_comb begin
    strictLvl = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--)
      if (lvlHit[l]) strictLvl = LVL_W'(l);
  end

  // levels below the fairness base bypass slot sharing
  always_comb begin
    urgentHit = 1'b0;
    for (int l = 0; l < FAIR_BASE; l++)
      urgentHit = urgentHit | lvlHit[l];
  end

  // favoured level from trailing zeros of the slot count
  always_comb begin
    int tz;
    logic seenOne;
    tz      = 0;
    seenOne = 1'b0;
    for (int b = 0; b < SLOT_W; b++) begin
      if (!seenOne && slotCnt[b]) seenOne = 1'b1;
      else if (!seenOne)          tz = tz + 1;
    end
    if (tz > NUM_LVL - 1 - FAIR_BASE) tz = NUM_LVL - 1 - FAIR_BASE;
    favLvl = LVL_W'(FAIR_BASE + tz);
  end

  always_comb begin
    if (fairEn && !urgentHit && lvlHit[favLvl]) chosenLvl = favLvl;
    else                                        chosenLvl = strictLvl;
    pickVec   = lvlPick[chosenLvl];
    pickValid = |lvlHit;
  end

  function automatic logic [CH_W-1:0] ohToIdx(input logic [NUM_CH-1:0] oh);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (oh[i]) r = CH_W'(i);
    return r;
  endfunction

  // grant, slot count and level pointers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantVec <= '0;
      grantLvl <= '0;
      slotCnt  <= '0;
      for (int l = 0; l < NUM_LVL; l++) lastIdx[l] <= CH_W'(NUM_CH - 1);
    end else begin
      if (strb.issue) begin
        grantVec <= pickVec;
        grantLvl <= chosenLvl;
        if (int'(chosenLvl) >= FAIR_BASE) slotCnt <= slotCnt + 1'b1;
      end else if (strb.retire) begin
        grantVec <= '0;
        for (int l = 0; l < NUM_LVL; l++)
          if (grantLvl == LVL_W'(l)) lastIdx[l] <= ohToIdx(grantVec);
      end
    end
  end

endmodule

// File: rtl/dmaArbControl.sv
module dmaArbControl
  import dmaArbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      pickValid,
  input  logic      xferDone,
  output arbStrobeT strb,
  output logic      grantValid,
  output logic      cpuGnt
);

  typedef enum logic {ST_IDLE, ST_BUSY} stateT;
  stateT state;

  always_comb begin
    strb.issue  = (state == ST_IDLE) && !cpuReq && pickValid;
    strb.retire = (state == ST_BUSY) && xferDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            state <= ST_IDLE;
    else if (strb.issue)  state <= ST_BUSY;
    else if (strb.retire) state <= ST_IDLE;
  end

  assign grantValid = (state == ST_BUSY);
  assign cpuGnt     = cpuReq && (state == ST_IDLE);

endmodule

// File: rtl/dmaArbiter.sv
module dmaArbiter
  import dmaArbPkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int LVL_W  = 3,
  parameter int SLOT_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuReq,
  output logic                    cpuGnt,
  input  logic [NUM_CH-1:0]       chReq,
  input  logic [NUM_CH*LVL_W-1:0] chLevel,
  input  logic [NUM_CH-1:0]       rrEn,
  input  logic                    fairEn,
  input  logic                    xferDone,
  output logic [NUM_CH-1:0]       grantVec,
  output logic                    grantValid
);

  arbStrobeT strb;
  logic      pickValid;

  dmaArbControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .pickValid  (pickValid),
    .xferDone   (xferDone),
    .strb       (strb),
    .grantValid (grantValid),
    .cpuGnt     (cpuGnt)
  );

  dmaArbDatapath #(
    .NUM_CH (NUM_CH),
    .LVL_W  (LVL_W),
    .SLOT_W (SLOT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .chReq     (chReq),
    .chLevel   (chLevel),
    .rrEn      (rrEn),
    .fairEn    (fairEn),
    .strb      (strb),
    .pickValid (pickValid),
    .grantVec  (grantVec)
  );

endmodule

// File: rtl/dmaArbChecker.sv
module dmaArbChecker #(
  parameter int NUM_CH = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuGnt,
  input logic [NUM_CH-1:0] chReq,
  input logic              xferDone,
  input logic [NUM_CH-1:0] grantVec,
  input logic              grantValid
);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R1

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (grantVec != '0)); // R1

  AST_CPU_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && cpuReq) |=> !grantValid); // R2

  AST_CPU_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    cpuGnt |-> !grantValid); // R2

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !xferDone) |=> (grantValid && $stable(grantVec))); // R4

  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && xferDone) |=> !grantValid); // R4

  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && !cpuReq && chReq != '0) |=> ((grantVec & $past(chReq)) != '0)); // R5

endmodule

bind dmaArbiter dmaArbChecker #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cpuReq     (cpuReq),
  .cpuGnt     (cpuGnt),
  .chReq      (chReq),
  .xferDone   (xferDone),
  .grantVec   (grantVec),
  .grantValid (grantValid)
);

// File: tb/test_dmaArbiter.sv
module test_dmaArbiter;

  localparam int NCH = 24;
  localparam int LW  = 3;

  typedef struct packed {
    logic [NCH-1:0] req;
    logic [NCH-1:0] rr;
    logic           fair;
    logic [4:0]     exp;
  } vecT;

  // levels fixed: channel i sits at level i/3
  localparam vecT VEC [14] = '{
    '{24'h200040, 24'hFFFFFF, 1'b1, 5'd21}, // R6 slot 0 -> level 7
    '{24'h000240, 24'hFFFFFF, 1'b1, 5'd6},  // R6 odd slot -> level 2
    '{24'h0002C0, 24'hFFFFFF, 1'b1, 5'd9},  // R6 slot 2 -> level 3
    '{24'h0000C0, 24'hFFFFFF, 1'b1, 5'd7},  // R8 rotation at level 2
    '{24'h001001, 24'hFFFFFF, 1'b1, 5'd0},  // R3 level 0 bypasses slots
    '{24'h001008, 24'hFFFFFF, 1'b1, 5'd3},  // R3 level 1 bypasses slots
    '{24'h001040, 24'hFFFFFF, 1'b1, 5'd12}, // R11 slot still 4 -> level 4
    '{24'h200000, 24'hFFFFFF, 1'b1, 5'd21}, // R7 favoured absent
    '{24'h000240, 24'hFFFFFF, 1'b0, 5'd6},  // R3 fairness off, R8 wrap
    '{24'h0001C0, 24'hFFFEFF, 1'b1, 5'd8},  // R9 head of line
    '{24'h0001C0, 24'hFFFEFF, 1'b1, 5'd8},  // R9 head again
    '{24'h0001C0, 24'hFFFFFF, 1'b1, 5'd6},  // R8 after head, wrap
    '{24'h400400, 24'hFFFFFF, 1'b1, 5'd10}, // R6 slot 10 -> level 3
    '{24'h000E00, 24'hFFFFFF, 1'b1, 5'd11}  // R7 R8 fallback rotation
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuReq = 1'b0;
  logic              cpuGnt;
  logic [NCH-1:0]    chReq = '0;
  logic [NCH*LW-1:0] chLevel;
  logic [NCH-1:0]    rrEn = '1;
  logic              fairEn = 1'b1;
  logic              xferDone = 1'b0;
  logic [NCH-1:0]    grantVec;
  logic              grantValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) chLevel[i*LW +: LW] = LW'(i / 3);
  end

  dmaArbiter i_dmaArbiter (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuGnt     (cpuGnt),
    .chReq      (chReq),
    .chLevel    (chLevel),
    .rrEn       (rrEn),
    .fairEn     (fairEn),
    .xferDone   (xferDone),
    .grantVec   (grantVec),
    .grantValid (grantValid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 grantVec after reset", 32'(grantVec), 32'h0);
    check("R10 grantValid after reset", 32'(grantValid), 32'h0);
    check("R2 cpuGnt idle no cpu", 32'(cpuGnt), 32'h0);

    // table of arbitration slots
    for (int v = 0; v < 14; v++) begin
      chReq  = VEC[v].req;
      rrEn   = VEC[v].rr;
      fairEn = VEC[v].fair;
      @(negedge clk);
      check($sformatf("R1 R3 R5 R6 R7 R8 R9 R11 vector %0d grant", v),
            32'(grantVec), 32'(1) << VEC[v].exp);
      check($sformatf("R1 vector %0d valid", v), 32'(grantValid), 32'h1);
      xferDone = 1'b1;
      @(negedge clk);
      xferDone = 1'b0;
      chReq    = '0;
      check($sformatf("R4 vector %0d release", v), 32'(grantValid), 32'h0);
    end
    rrEn   = '1;
    fairEn = 1'b1;

    // CPU override while idle
    cpuReq = 1'b1;
    chReq  = 24'h000001;
    @(negedge clk);
    check("R2 no grant under cpu", 32'(grantValid), 32'h0);
    check("R2 cpuGnt high idle", 32'(cpuGnt), 32'h1);
    cpuReq = 1'b0;
    @(negedge clk);
    check("R5 grant after cpu drops", 32'(grantVec), 32'h1);
    cpuReq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R4 grant held under cpu", 32'(grantVec), 32'h1);
      check("R2 cpuGnt low while busy", 32'(cpuGnt), 32'h0);
    end
    xferDone = 1'b1;
    cpuReq   = 1'b0;
    chReq    = '0;
    @(negedge clk);
    xferDone = 1'b0;
    check("R4 release after cpu test", 32'(grantValid), 32'h0);

    // urgent request mid-transaction waits for done
    chReq = 24'h200000;
    @(negedge clk);
    check("R7 slot 12 falls back to level 7", 32'(grantVec), 32'h200000);
    chReq = 24'h200001;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R4 no preemption", 32'(grantVec), 32'h200000);
    end
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    check("R4 gap after done", 32'(grantValid), 32'h0);
    @(negedge clk);
    check("R3 urgent channel next", 32'(grantVec), 32'h1);
    xferDone = 1'b1;
    chReq    = '0;
    @(negedge clk);
    xferDone = 1'b0;
    check("R4 final release", 32'(grantValid), 32'h0);

    // nothing requested
    repeat (2) @(negedge clk);
    check("R5 no request no grant", 32'(grantValid), 32'h0);
    check("R1 empty vector", 32'(grantVec), 32'h0);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule